// File: doc/BRIEF.md
# Four-Thread Fetch Buffer and Decode Dispatcher

This block is the instruction front end of a core that runs four hardware threads at once. It decides which thread may fetch next, and it takes the 32-byte packets that come back from the instruction cache. It keeps a separate word buffer for each thread and, every cycle, hands 32-bit instructions to two decode slots of four lanes each.

A small parser looks at every arriving word. Words of one chosen instruction class are completed in the front end. They are removed before buffering, so they never take a decode lane, and a retire pulse reports them with the owning thread.

Each decode slot is filled from at most two threads. A thread feeds at most one slot per cycle, and a thread's words always leave in program order. A per-thread flush empties a buffer in one cycle and cancels any fetch still in flight for that thread.

Top module: `smt_fetch_dispatch`

## Requirements
- R1: After reset no decode lane is valid and `drop_vld` is low. With every buffer empty, `req_vld` is high with `req_tid` = 0.
- R2: The fetch request goes to the first thread, in round-robin order, that has no outstanding request and at least 8 free buffer words. The order starts at the thread after the last granted one, or at thread 0 after reset. A grant happens in a cycle where `req_vld` and `req_rdy` are both high.
- R3: Packet word i sits at `pkt_data[32i+31:32i]` and counts only when `pkt_mask[i]` is set. Kept words join the end of that thread's buffer in ascending i order, and masked-off words are ignored.
- R4: A valid word whose bits [6:0] equal `DROP_OPC` (default 7'b0001011) never reaches a lane. In the cycle after the accepting edge, `drop_vld` is high with `drop_tid` = packet thread and `drop_cnt` = number of such words. There is no pulse when that number is zero.
- R5: Lane index i = slot*4 + lane selects `dec_vld[i]`, `dec_tid[2i+1:2i]` and `dec_instr[32i+31:32i]`. The valid lanes of a slot are contiguous from lane 0, and a slot holds words of at most two threads.
- R6: Threads are visited in round-robin order from the decode pointer. Each non-empty thread gives min(its count, lanes left) words to the current slot. A slot closes when its 4 lanes are full or it has two threads. A thread feeds at most one slot per cycle.
- R7: A thread's words leave in program order: oldest first, lower lanes first, and continuing across cycles.
- R8: The decode pointer is 0 after reset. After a cycle in which any thread was served, it moves to the thread after the first one served; otherwise it is unchanged.
- R9: In a cycle with `flush[t]` high, no lane carries thread t and its buffered words are discarded, so no lane carries t in the next cycle.
- R10: A packet answering a request that was granted before, or in, a flush cycle of its thread is discarded, and no retire pulse is raised for it.
- R11: A thread has at most one outstanding fetch, which stays outstanding until its packet arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 4 | Per-thread redirect flush |
| req_rdy | input | 1 | Cache accepts a fetch request this cycle |
| req_vld | output | 1 | A fetch request is offered |
| req_tid | output | 2 | Thread of the offered request |
| pkt_vld | input | 1 | Returned packet valid |
| pkt_tid | input | 2 | Thread of the returned packet |
| pkt_data | input | 256 | Eight 32-bit instruction words |
| pkt_mask | input | 8 | Per-word valid mask |
| dec_vld | output | 8 | Lane valid, lane i = slot*4 + lane |
| dec_tid | output | 16 | Lane thread, 2 bits per lane |
| dec_instr | output | 256 | Lane instruction, 32 bits per lane |
| drop_vld | output | 1 | Front-end retire pulse |
| drop_tid | output | 2 | Thread of the retired words |
| drop_cnt | output | 4 | Number of words retired early |

## Verification
The case that needs the most care is a thread's returning packet and that same thread's decode pops landing on one clock edge. A flush of that thread can land on the same edge as well. The buffer count must then add the kept words and subtract the popped ones, or throw away both. The bench answers fetches after a pseudo-random delay and issues rare random flushes while all four buffers are draining, so these collisions happen again and again. A cycle-exact model of the queues then predicts every lane, the request and the retire pulse, and any mismatch is reported.

// File: rtl/fbd_pkg.sv
// Shared constants of the four-thread fetch dispatcher.
// Assumes NTHR and LANES are powers of two.
package fbd_pkg;
    localparam int NTHR         = 4;   // hardware threads
    localparam int PKT_WORDS    = 8;   // words per fetch packet
    localparam int SLOTS        = 2;   // decode slots
    localparam int LANES        = 4;   // lanes per slot
    localparam int THR_PER_SLOT = 2;   // distinct threads per slot
    localparam int IW           = 32;  // instruction width
    localparam int OPW          = 7;   // opcode field width
    localparam int TW           = $clog2(NTHR);
    localparam int NL           = SLOTS * LANES;
    localparam int PW           = $clog2(PKT_WORDS);
    localparam int PCW          = $clog2(PKT_WORDS + 1);
    localparam int LCW          = $clog2(LANES + 1);
    localparam int LIW          = $clog2(LANES);
endpackage

// File: rtl/fbd_fetch_arb.sv
// Round-robin fetch request arbiter. Offers the first eligible thread after
// the last granted one. Assumes elig already excludes threads with a
// request in flight or without room for a full packet.
module fbd_fetch_arb
    import fbd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTHR-1:0] elig,
    input  logic            rdy,
    output logic            req_vld,
    output logic [TW-1:0]   req_tid,
    output logic [NTHR-1:0] grant
);
    logic [TW-1:0] ptr_q;
    logic [TW-1:0] scan;

    // Find the first eligible thread starting at the pointer.
    always_comb begin
        req_vld = 1'b0;
        req_tid = '0;
        scan    = '0;
        for (int o = 0; o < NTHR; o++) begin
            scan = ptr_q + TW'(o);
            if (!req_vld && elig[scan]) begin
                req_vld = 1'b1;
                req_tid = scan;
            end
        end
    end

    // Turn the chosen thread into a one-hot grant when the cache accepts.
    always_comb begin
        grant = '0;
        if (req_vld && rdy) grant[req_tid] = 1'b1;
    end

    // Move the pointer past the granted thread.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr_q <= '0;
        else if (req_vld && rdy)   ptr_q <= req_tid + TW'(1);
    end
endmodule

// File: rtl/fbd_drop_parse.sv
// Packet parser. Marks valid words of the early-retire class, computes the
// compacted position of each kept word, and counts kept and dropped words.
// Purely combinational.
module fbd_drop_parse
    import fbd_pkg::*;
#(
    parameter logic [OPW-1:0] DROP_OPC = 7'b0001011
)(
    input  logic [PKT_WORDS*IW-1:0] data,
    input  logic [PKT_WORDS-1:0]    mask,
    output logic [PKT_WORDS-1:0]    keep,
    output logic [PW-1:0]           pos [PKT_WORDS],
    output logic [PCW-1:0]          nkeep,
    output logic [PCW-1:0]          ndrop
);
    // Classify words and build the running kept-word index.
    always_comb begin
        nkeep = '0;
        ndrop = '0;
        for (int i = 0; i < PKT_WORDS; i++) begin
            pos[i]  = PW'(nkeep);
            keep[i] = mask[i] && (data[i*IW +: OPW] != DROP_OPC);
            if (keep[i])                             nkeep = nkeep + PCW'(1);
            if (mask[i] && (data[i*IW +: OPW] == DROP_OPC)) ndrop = ndrop + PCW'(1);
        end
    end
endmodule

// File: rtl/fbd_thread_buf.sv
// Per-thread circular word buffer. Writes up to a packet of compacted words
// and pops up to LANES words per cycle; flush empties it and wins over both.
// Assumes the caller never pops more than count nor writes past DEPTH.
module fbd_thread_buf
    import fbd_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    wr_en,
    input  logic [PKT_WORDS*IW-1:0] wr_data,
    input  logic [PKT_WORDS-1:0]    wr_keep,
    input  logic [PW-1:0]           wr_pos [PKT_WORDS],
    input  logic [PCW-1:0]          wr_n,
    input  logic [LCW-1:0]          pop_n,
    output logic [IW-1:0]           head [LANES],
    output logic [CW-1:0]           count
);
    logic [IW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] cnt_q;

    // Store kept words at their compacted positions.
    always_ff @(posedge clk) begin
        for (int i = 0; i < PKT_WORDS; i++) begin
            if (wr_en && !flush && wr_keep[i])
                mem[wr_ptr_q + AW'(wr_pos[i])] <= wr_data[i*IW +: IW];
        end
    end

    // Maintain pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (flush) begin
            rd_ptr_q <= wr_ptr_q;
            cnt_q    <= '0;
        end else begin
            rd_ptr_q <= rd_ptr_q + AW'(pop_n);
            wr_ptr_q <= wr_ptr_q + (wr_en ? AW'(wr_n) : AW'(0));
            cnt_q    <= cnt_q + (wr_en ? CW'(wr_n) : CW'(0)) - CW'(pop_n);
        end
    end

    // Present the oldest LANES words.
    always_comb begin
        for (int j = 0; j < LANES; j++) head[j] = mem[rd_ptr_q + AW'(j)];
    end

    assign count = cnt_q;
endmodule

// File: rtl/fbd_slot_sched.sv
// Decode slot scheduler. Visits threads round-robin from its pointer and
// fills slot 0 then slot 1 greedily; a slot closes when full or when it has
// THR_PER_SLOT threads. Each thread feeds at most one slot per cycle.
module fbd_slot_sched
    import fbd_pkg::*;
#(
    parameter int CW = 5
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cnt  [NTHR],
    input  logic [IW-1:0]    head [NTHR][LANES],
    output logic [LCW-1:0]   pop  [NTHR],
    output logic [NL-1:0]    dec_vld,
    output logic [NL*TW-1:0] dec_tid,
    output logic [NL*IW-1:0] dec_instr
);
    logic [TW-1:0] ptr_q, scan, first_t;
    logic          any_t;
    int            slot_i, fill_i, used_i, n_i, c_i;
    int            tslot [NTHR];
    int            toff  [NTHR];
    int            tn    [NTHR];

    // Greedy assignment of thread runs to slots.
    always_comb begin
        slot_i  = 0;
        fill_i  = 0;
        used_i  = 0;
        n_i     = 0;
        c_i     = 0;
        any_t   = 1'b0;
        first_t = '0;
        scan    = '0;
        for (int t = 0; t < NTHR; t++) begin
            tslot[t] = 0;
            toff[t]  = 0;
            tn[t]    = 0;
        end
        for (int o = 0; o < NTHR; o++) begin
            scan = ptr_q + TW'(o);
            c_i  = int'(cnt[scan]);
            if (c_i > 0 && slot_i < SLOTS) begin
                n_i = (c_i < LANES - fill_i) ? c_i : LANES - fill_i;
                tslot[scan] = slot_i;
                toff[scan]  = fill_i;
                tn[scan]    = n_i;
                if (!any_t) first_t = scan;
                any_t  = 1'b1;
                fill_i = fill_i + n_i;
                used_i = used_i + 1;
                if (fill_i == LANES || used_i == THR_PER_SLOT) begin
                    slot_i = slot_i + 1;
                    fill_i = 0;
                    used_i = 0;
                end
            end
        end
    end

    // Route buffer head words onto the lanes.
    always_comb begin
        dec_vld   = '0;
        dec_tid   = '0;
        dec_instr = '0;
        for (int s = 0; s < SLOTS; s++) begin
            for (int l = 0; l < LANES; l++) begin
                for (int t = 0; t < NTHR; t++) begin
                    if (tn[t] > 0 && tslot[t] == s && l >= toff[t] && l < toff[t] + tn[t]) begin
                        dec_vld[s*LANES + l]          = 1'b1;
                        dec_tid[(s*LANES + l)*TW +: TW] = TW'(t);
                        dec_instr[(s*LANES + l)*IW +: IW] = head[t][LIW'(l - toff[t])];
                    end
                end
            end
        end
    end

    // Pop counts follow the assignment.
    always_comb begin
        for (int t = 0; t < NTHR; t++) pop[t] = LCW'(tn[t]);
    end

    // Advance the pointer past the first thread served.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= '0;
        else if (any_t) ptr_q <= first_t + TW'(1);
    end
endmodule

// File: rtl/smt_fetch_dispatch.sv
// Top of the four-thread fetch dispatcher: fetch arbitration, packet parse
// with early retire, per-thread buffers and two decode slots.
// Assumes the cache returns packets only for threads with a request
// outstanding, in request order per thread, and that decode always accepts.
module smt_fetch_dispatch
    import fbd_pkg::*;
#(
    parameter int             DEPTH    = 16,
    parameter logic [OPW-1:0] DROP_OPC = 7'b0001011
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NTHR-1:0]         flush,
    input  logic                    req_rdy,
    output logic                    req_vld,
    output logic [TW-1:0]           req_tid,
    input  logic                    pkt_vld,
    input  logic [TW-1:0]           pkt_tid,
    input  logic [PKT_WORDS*IW-1:0] pkt_data,
    input  logic [PKT_WORDS-1:0]    pkt_mask,
    output logic [NL-1:0]           dec_vld,
    output logic [NL*TW-1:0]        dec_tid,
    output logic [NL*IW-1:0]        dec_instr,
    output logic                    drop_vld,
    output logic [TW-1:0]           drop_tid,
    output logic [PCW-1:0]          drop_cnt
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [NTHR-1:0]      pend_q, disc_q, elig, grant, arrive, wr_en;
    logic [CW-1:0]        count   [NTHR];
    logic [CW-1:0]        cnt_eff [NTHR];
    logic [IW-1:0]        head    [NTHR][LANES];
    logic [LCW-1:0]       pop     [NTHR];
    logic [PKT_WORDS-1:0] keep;
    logic [PW-1:0]        pos     [PKT_WORDS];
    logic [PCW-1:0]       nkeep, ndrop;

    // Per-thread eligibility, arrival and write enable.
    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            elig[t]    = !pend_q[t] && (count[t] <= CW'(DEPTH - PKT_WORDS));
            arrive[t]  = pkt_vld && (pkt_tid == TW'(t));
            wr_en[t]   = arrive[t] && !disc_q[t] && !flush[t];
            cnt_eff[t] = flush[t] ? '0 : count[t];
        end
    end

    fbd_fetch_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .rdy     (req_rdy),
        .req_vld (req_vld),
        .req_tid (req_tid),
        .grant   (grant)
    );

    fbd_drop_parse #(.DROP_OPC(DROP_OPC)) u_parse (
        .data  (pkt_data),
        .mask  (pkt_mask),
        .keep  (keep),
        .pos   (pos),
        .nkeep (nkeep),
        .ndrop (ndrop)
    );

    for (genvar t = 0; t < NTHR; t++) begin : g_buf
        fbd_thread_buf #(.DEPTH(DEPTH)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush[t]),
            .wr_en   (wr_en[t]),
            .wr_data (pkt_data),
            .wr_keep (keep),
            .wr_pos  (pos),
            .wr_n    (nkeep),
            .pop_n   (pop[t]),
            .head    (head[t]),
            .count   (count[t])
        );
    end

    fbd_slot_sched #(.CW(CW)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt_eff),
        .head      (head),
        .pop       (pop),
        .dec_vld   (dec_vld),
        .dec_tid   (dec_tid),
        .dec_instr (dec_instr)
    );

    // Track the outstanding fetch and the stale-packet discard per thread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            disc_q <= '0;
        end else begin
            for (int t = 0; t < NTHR; t++) begin
                if (grant[t])       pend_q[t] <= 1'b1;
                else if (arrive[t]) pend_q[t] <= 1'b0;
                if (flush[t])       disc_q[t] <= (pend_q[t] && !arrive[t]) || grant[t];
                else if (arrive[t]) disc_q[t] <= 1'b0;
            end
        end
    end

    // Raise the early-retire pulse for an accepted packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_vld <= 1'b0;
            drop_tid <= '0;
            drop_cnt <= '0;
        end else begin
            drop_vld <= (|wr_en) && (ndrop != '0);
            drop_tid <= pkt_tid;
            drop_cnt <= ndrop;
        end
    end
endmodule

// File: rtl/fbd_checker.sv
// Property checker for smt_fetch_dispatch, attached with bind below.
// Observes ports only.
module fbd_checker
    import fbd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NTHR-1:0]  flush,
    input logic             req_rdy,
    input logic             req_vld,
    input logic [TW-1:0]    req_tid,
    input logic             pkt_vld,
    input logic [TW-1:0]    pkt_tid,
    input logic [NL-1:0]    dec_vld,
    input logic [NL*TW-1:0] dec_tid,
    input logic             drop_vld,
    input logic [TW-1:0]    drop_tid
);
    logic [NTHR-1:0]  pres  [SLOTS];
    logic [SLOTS-1:0] where [NTHR];
    logic [NTHR-1:0]  active;

    // Which threads appear in which slot.
    always_comb begin
        active = '0;
        for (int t = 0; t < NTHR; t++) where[t] = '0;
        for (int s = 0; s < SLOTS; s++) begin
            pres[s] = '0;
            for (int l = 0; l < LANES; l++) begin
                for (int t = 0; t < NTHR; t++) begin
                    if (dec_vld[s*LANES + l] && dec_tid[(s*LANES + l)*TW +: TW] == TW'(t)) begin
                        pres[s][t]  = 1'b1;
                        where[t][s] = 1'b1;
                        active[t]   = 1'b1;
                    end
                end
            end
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        p_slot_threads_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(pres[s]) <= THR_PER_SLOT)
            else $error("slot %0d holds too many threads", s);
        for (genvar l = 1; l < LANES; l++) begin : g_lane
            p_lane_packed_r5: assert property (@(posedge clk) disable iff (!rst_n)
                dec_vld[s*LANES + l] |-> dec_vld[s*LANES + l - 1])
                else $error("slot %0d lane %0d valid with a gap below", s, l);
        end
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        p_one_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(where[t]))
            else $error("thread %0d feeds two slots", t);
        p_flush_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
            flush[t] |-> !active[t])
            else $error("thread %0d on a lane while flushed", t);
        p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            flush[t] |=> !active[t])
            else $error("thread %0d on a lane after flush", t);
    end

    p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_rdy) |=> !(req_vld && req_tid == $past(req_tid)))
        else $error("second request for a thread with one in flight");

    p_drop_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drop_vld |-> ($past(pkt_vld) && drop_tid == $past(pkt_tid)))
        else $error("retire pulse without a matching packet");
endmodule

bind smt_fetch_dispatch fbd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .req_rdy  (req_rdy),
    .req_vld  (req_vld),
    .req_tid  (req_tid),
    .pkt_vld  (pkt_vld),
    .pkt_tid  (pkt_tid),
    .dec_vld  (dec_vld),
    .dec_tid  (dec_tid),
    .drop_vld (drop_vld),
    .drop_tid (drop_tid)
);

// File: tb/smt_fetch_dispatch_bench.sv
// Cycle-exact queue model of the dispatcher: sweeps every packet mask with
// random drop patterns, response delays and flushes.
module smt_fetch_dispatch_bench;
    import fbd_pkg::*;

    localparam logic [6:0] DOPC = 7'b0001011;
    localparam int         DEPTH = 16;

    logic                    clk, rst_n, req_rdy, req_vld, pkt_vld, drop_vld;
    logic [NTHR-1:0]         flush;
    logic [TW-1:0]           req_tid, pkt_tid, drop_tid;
    logic [PKT_WORDS*IW-1:0] pkt_data;
    logic [PKT_WORDS-1:0]    pkt_mask;
    logic [NL-1:0]           dec_vld;
    logic [NL*TW-1:0]        dec_tid;
    logic [NL*IW-1:0]        dec_instr;
    logic [PCW-1:0]          drop_cnt;

    smt_fetch_dispatch #(.DEPTH(DEPTH), .DROP_OPC(DOPC)) u_smt_fetch_dispatch (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_rdy(req_rdy),
        .req_vld(req_vld), .req_tid(req_tid), .pkt_vld(pkt_vld),
        .pkt_tid(pkt_tid), .pkt_data(pkt_data), .pkt_mask(pkt_mask),
        .dec_vld(dec_vld), .dec_tid(dec_tid), .dec_instr(dec_instr),
        .drop_vld(drop_vld), .drop_tid(drop_tid), .drop_cnt(drop_cnt)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Model state.
    logic [31:0] mq [NTHR][$];
    bit   mpend [NTHR];
    bit   mdisc [NTHR];
    int   mfptr = 0, mdptr = 0, seq = 1, mask_ctr = 0, r10_watch = -1;
    bit   e_dv = 0;
    int   e_dt = 0, e_dc = 0;
    logic [31:0] rs = 32'h1234_5678;

    // Driven values.
    logic [NTHR-1:0]         d_flush;
    logic                    d_rdy, d_pv;
    logic [TW-1:0]           d_pt;
    logic [PKT_WORDS*IW-1:0] d_data;
    logic [PKT_WORDS-1:0]    d_mask, d_drop;

    function automatic int rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return int'(rs & 32'h7fff_ffff);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Build a packet: dropped words and masked-off words carry the drop opcode.
    task automatic build_pkt(input int t, input logic [7:0] m, input logic [7:0] dm);
        d_pv = 1'b1; d_pt = TW'(t); d_mask = m; d_drop = dm;
        for (int i = 0; i < PKT_WORDS; i++) begin
            if (m[i] && !dm[i]) d_data[i*IW +: IW] = {t[1:0], seq[22:0], 7'h13};
            else                d_data[i*IW +: IW] = {2'b11, seq[22:0], DOPC};
            seq++;
        end
    endtask

    task automatic idle_inputs();
        d_flush = '0; d_rdy = 1'b0; d_pv = 1'b0; d_pt = '0;
        d_data = '0; d_mask = '0; d_drop = '0;
    endtask

    task automatic gen_rand();
        int st;
        idle_inputs();
        d_rdy = (rnd() % 8) != 0;
        for (int t = 0; t < NTHR; t++) d_flush[t] = (rnd() % 40) == 0;
        st = rnd() % NTHR;
        for (int o = 0; o < NTHR; o++) begin
            int t;
            t = (st + o) % NTHR;
            if (!d_pv && mpend[t] && (rnd() % 2) == 1) begin
                build_pkt(t, 8'(mask_ctr), 8'(rnd() & rnd()));
                mask_ctr++;
            end
        end
    endtask

    // One cycle: drive, compare against the model, then advance the model.
    task automatic do_cycle();
        bit   ev;
        int   eg, cnt [NTHR], tslot [NTHR], toff [NTHR], tn [NTHR];
        int   slot, fill, used, first;
        bit   lv [NL];
        int   lt [NL];
        logic [31:0] li [NL];
        @(negedge clk);
        flush = d_flush; req_rdy = d_rdy; pkt_vld = d_pv; pkt_tid = d_pt;
        pkt_data = d_data; pkt_mask = d_mask;
        #1;
        // Fetch request (R2, R11).
        ev = 0; eg = 0;
        for (int o = 0; o < NTHR; o++) begin
            int t;
            t = (mfptr + o) % NTHR;
            if (!ev && !mpend[t] && mq[t].size() <= DEPTH - PKT_WORDS) begin ev = 1; eg = t; end
        end
        chk(req_vld == ev, "R2 R11", "req_vld", req_vld, ev);
        if (ev) chk(int'(req_tid) == eg, "R2", "req_tid", req_tid, eg);
        // Decode lanes (R5 R6 R7 R8).
        slot = 0; fill = 0; used = 0; first = -1;
        for (int t = 0; t < NTHR; t++) begin
            cnt[t] = d_flush[t] ? 0 : mq[t].size();
            tn[t] = 0; tslot[t] = 0; toff[t] = 0;
        end
        for (int o = 0; o < NTHR; o++) begin
            int t;
            t = (mdptr + o) % NTHR;
            if (cnt[t] > 0 && slot < SLOTS) begin
                tn[t] = (cnt[t] < LANES - fill) ? cnt[t] : LANES - fill;
                tslot[t] = slot; toff[t] = fill;
                if (first < 0) first = t;
                fill += tn[t]; used++;
                if (fill == LANES || used == THR_PER_SLOT) begin slot++; fill = 0; used = 0; end
            end
        end
        for (int i = 0; i < NL; i++) begin lv[i] = 0; lt[i] = 0; li[i] = '0; end
        for (int t = 0; t < NTHR; t++)
            for (int k = 0; k < tn[t]; k++) begin
                lv[tslot[t]*LANES + toff[t] + k] = 1;
                lt[tslot[t]*LANES + toff[t] + k] = t;
                li[tslot[t]*LANES + toff[t] + k] = mq[t][k];
            end
        for (int i = 0; i < NL; i++) begin
            chk(dec_vld[i] == lv[i], "R5 R6", $sformatf("lane %0d valid", i), dec_vld[i], lv[i]);
            if (lv[i] && dec_vld[i]) begin
                chk(int'(dec_tid[i*TW +: TW]) == lt[i], "R8", $sformatf("lane %0d tid", i),
                    dec_tid[i*TW +: TW], lt[i]);
                chk(dec_instr[i*IW +: IW] == li[i], "R3 R7", $sformatf("lane %0d instr", i),
                    dec_instr[i*IW +: IW], li[i]);
            end
        end
        for (int t = 0; t < NTHR; t++) begin
            if (d_flush[t]) begin
                int hits;
                hits = 0;
                for (int i = 0; i < NL; i++)
                    if (dec_vld[i] && int'(dec_tid[i*TW +: TW]) == t) hits++;
                chk(hits == 0, "R9", "lanes of flushed thread", hits, 0);
            end
        end
        if (r10_watch >= 0) begin
            int hits;
            hits = 0;
            for (int i = 0; i < NL; i++)
                if (dec_vld[i] && int'(dec_tid[i*TW +: TW]) == r10_watch) hits++;
            chk(hits == 0 && !drop_vld, "R10", "stale packet visible", hits + int'(drop_vld), 0);
        end
        // Retire pulse (R4).
        chk(drop_vld == e_dv, "R4", "drop_vld", drop_vld, e_dv);
        if (e_dv) begin
            chk(int'(drop_tid) == e_dt, "R4", "drop_tid", drop_tid, e_dt);
            chk(int'(drop_cnt) == e_dc, "R4", "drop_cnt", drop_cnt, e_dc);
        end
        @(posedge clk);
        // Advance the model.
        for (int t = 0; t < NTHR; t++) repeat (tn[t]) void'(mq[t].pop_front());
        if (first >= 0) mdptr = (first + 1) % NTHR;
        e_dv = 0; e_dt = 0; e_dc = 0;
        for (int t = 0; t < NTHR; t++) begin
            bit arr, gr, wr, np, nd;
            arr = d_pv && int'(d_pt) == t;
            gr  = ev && d_rdy && eg == t;
            wr  = arr && !mdisc[t] && !d_flush[t];
            np  = gr ? 1'b1 : (arr ? 1'b0 : mpend[t]);
            nd  = d_flush[t] ? ((mpend[t] && !arr) || gr) : (arr ? 1'b0 : mdisc[t]);
            if (d_flush[t]) mq[t].delete();
            if (wr) begin
                int nd_cnt;
                nd_cnt = 0;
                for (int i = 0; i < PKT_WORDS; i++) begin
                    if (d_mask[i] && !d_drop[i]) mq[t].push_back(d_data[i*IW +: IW]);
                    if (d_mask[i] && d_drop[i])  nd_cnt++;
                end
                if (nd_cnt > 0) begin e_dv = 1; e_dt = t; e_dc = nd_cnt; end
            end
            mpend[t] = np; mdisc[t] = nd;
        end
        if (ev && d_rdy) mfptr = (eg + 1) % NTHR;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NTHR; t++) begin mpend[t] = 0; mdisc[t] = 0; end
        idle_inputs();
        rst_n = 1'b0; flush = '0; req_rdy = 1'b0; pkt_vld = 1'b0; pkt_tid = '0;
        pkt_data = '0; pkt_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        chk(dec_vld == '0, "R1", "dec_vld after reset", dec_vld, 0);
        chk(drop_vld == 1'b0, "R1", "drop_vld after reset", drop_vld, 0);
        chk(req_vld && req_tid == '0, "R1", "first request", {req_vld, req_tid}, 3'b100);

        // R10: request for thread 0, flush before the answer, then the answer.
        idle_inputs(); d_rdy = 1'b1; do_cycle();
        idle_inputs(); d_flush[0] = 1'b1; do_cycle();
        idle_inputs(); build_pkt(0, 8'hFF, 8'h01); do_cycle();
        r10_watch = 0;
        idle_inputs(); repeat (3) do_cycle();
        r10_watch = -1;

        // R3, R4, R7: single thread, fixed mask and drops, checked in order.
        idle_inputs(); d_rdy = 1'b1; do_cycle();
        idle_inputs(); repeat (2) do_cycle();
        for (int t = 0; t < NTHR; t++)
            if (mpend[t]) begin idle_inputs(); build_pkt(t, 8'hB7, 8'h12); do_cycle(); end
        idle_inputs(); repeat (4) do_cycle();

        // Sweep of every mask under random traffic, flushes and collisions.
        for (int c = 0; c < 3000; c++) begin
            gen_rand();
            do_cycle();
        end
        idle_inputs(); repeat (8) do_cycle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule